// File: doc/BRIEF.md
# I2C Byte Master with Status Codes

A byte-level two-wire bus master controlled through a single command write. Each write carries control bits (go, enable, start, stop, acknowledge-enable) and a data byte. A write with go set, accepted while the controller is idle, launches exactly one bus action. The action is one of four: a START or repeated START, transmission of an address or data byte, reception of a data byte answered with ACK or NACK, or a STOP. When the action ends, the controller raises `done` and reports a 5-bit status code.

The 5-bit code is the conventional 8-bit status value with its three low bits dropped. For example, 8-bit 0x08 reads as code 0x01, and 8-bit 0x58 reads as code 0x0B. The code tells software exactly how the bus reacted, so software does not have to infer it from a busy flag.

The bus is driven through open-drain pull-down enables, and the resolved SCL/SDA levels are sampled back. A programmable divider sets the bit rate. While a byte is on the bus, the controller watches for a START or STOP that does not belong there. If it sees one, it abandons the byte, releases both lines without driving a STOP, and reports a bus-error code.

Top module: `twm_master`

## Requirements
- R1: After reset, `done` and `sto_pend` are 0, `stat_code` is 0x1F, and both pull-down enables are off.
- R2: On a START from a free bus, SDA falls while SCL is high and SCL is then pulled low. The action ends with code 0x01.
- R3: On a START while the bus is already held by this master (repeated START), SDA is first released with SCL low, and then the START edge is made. The action ends with code 0x02.
- R4: The first byte after a START is the address byte, and its bit 0 set selects receive. Transmit address gives 0x03 on ACK and 0x04 on NACK. Receive address gives 0x08 on ACK and 0x09 on NACK.
- R5: Data bytes in transmit mode go out MSB first, and SDA changes only while SCL is low. The action ends with code 0x05 on ACK and 0x06 on NACK.
- R6: In receive mode, a data byte is shifted in MSB first and presented on `rx_byte`. In the ninth bit the master drives SDA low when acknowledge-enable is set (code 0x0A) and releases it otherwise (code 0x0B).
- R7: A STOP raises `sto_pend` on acceptance. It then releases SCL and afterwards releases SDA while SCL is high. On completion `sto_pend` clears, `done` is set and the code is 0x1F.
- R8: A command is accepted only when go is 1 and no action is running. Acceptance clears `done`, and `done` sets again when the action ends. A write with go 0 has no effect.
- R9: Each SCL low phase and each high phase lasts 8 + `rate_div` clock cycles, so the SCL period is 16 + 2·`rate_div` cycles. A high phase is counted only once the line is actually high, which lets a slave stretch the clock.
- R10: An SDA change while SCL stays high during a byte is a bus error. It gives code 0x00, releases both lines, clears `sto_pend` and sets `done`. The bus is then no longer held, so the next START reports 0x01.
- R11: An accepted write with enable 0 releases both lines, starts no action and leaves `done` and `stat_code` unchanged. The next START reports 0x01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_go | input | 1 | Launch bit; writing 1 clears `done` and starts an action |
| cmd_en | input | 1 | Enable; 0 releases the bus |
| cmd_sta | input | 1 | Request START / repeated START |
| cmd_sto | input | 1 | Request STOP |
| cmd_ack | input | 1 | Acknowledge received bytes |
| cmd_data | input | 8 | Byte to transmit (address or data) |
| rate_div | input | DIV_W | Bit-rate divider |
| scl_in | input | 1 | Resolved SCL line level |
| sda_in | input | 1 | Resolved SDA line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| done | output | 1 | Action complete |
| sto_pend | output | 1 | STOP requested and not yet on the bus |
| stat_code | output | 5 | Status code (8-bit status >> 3) |
| rx_byte | output | 8 | Last byte shifted in from the bus |

## Verification
The status code is rewritten only when an action finishes, so a wrong mode flag or a stale address-phase marker stays hidden until `done` rises. At that point it shows as a wrong code, one byte-time (18 SCL phases) after the command was accepted. A bit counter that is off by one, or a shift that runs the wrong way, shows at the end of the same byte: the captured bus bits or `rx_byte` come out rotated, and the ninth-bit ACK lands on a data bit. A wrong bus-ownership flag only shows at the next START, which then reports the repeated-START code instead of the START code, or the reverse.

// File: rtl/twm_master.sv
`timescale 1ns/1ps
module twm_master #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic             cmd_go,
  input  logic             cmd_en,
  input  logic             cmd_sta,
  input  logic             cmd_sto,
  input  logic             cmd_ack,
  input  logic [7:0]       cmd_data,
  input  logic [DIV_W-1:0] rate_div,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             done,
  output logic             sto_pend,
  output logic [4:0]       stat_code,
  output logic [7:0]       rx_byte
);
  localparam int CNT_W = DIV_W + 1;
  localparam logic [4:0] C_BUSERR = 5'h00, C_START = 5'h01, C_RSTART = 5'h02,
                         C_WA_ACK = 5'h03, C_WA_NAK = 5'h04, C_WD_ACK = 5'h05,
                         C_WD_NAK = 5'h06, C_RA_ACK = 5'h08, C_RA_NAK = 5'h09,
                         C_RD_ACK = 5'h0A, C_RD_NAK = 5'h0B, C_NONE   = 5'h1F;

  typedef enum logic [1:0] {S_IDLE, S_START, S_BYTE, S_STOP} state_t;

  state_t           st;
  logic [3:0]       step;
  logic             hi;
  logic [CNT_W-1:0] cnt;
  logic             owned, addr_ph, rd_mode, rx_op, ack_en;
  logic [7:0]       shreg;
  logic             scl_q, sda_q;
  logic [4:0]       byte_code;

  wire [CNT_W-1:0] half_m1 = {1'b0, rate_div} + CNT_W'(7);
  wire run    = scl_oe || scl_in;
  wire tick   = (cnt == '0) && run;
  wire accept = cmd_wr && cmd_go && (st == S_IDLE);
  wire bus_err = (st == S_BYTE) && hi && scl_in && scl_q && (sda_in != sda_q);
  wire ack_seen = !sda_in;
  wire rx_next  = !addr_ph && rd_mode;

  assign byte_code = rx_op   ? (ack_en ? C_RD_ACK : C_RD_NAK) :
                     addr_ph ? (rd_mode ? (ack_seen ? C_RA_ACK : C_RA_NAK)
                                        : (ack_seen ? C_WA_ACK : C_WA_NAK)) :
                               (ack_seen ? C_WD_ACK : C_WD_NAK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      step      <= '0;
      hi        <= 1'b0;
      cnt       <= '0;
      owned     <= 1'b0;
      addr_ph   <= 1'b0;
      rd_mode   <= 1'b0;
      rx_op     <= 1'b0;
      ack_en    <= 1'b0;
      shreg     <= '0;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      scl_oe    <= 1'b0;
      sda_oe    <= 1'b0;
      done      <= 1'b0;
      sto_pend  <= 1'b0;
      stat_code <= C_NONE;
      rx_byte   <= '0;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
      if (cnt != '0 && run) cnt <= cnt - 1'b1;

      if (bus_err) begin
        st        <= S_IDLE;
        scl_oe    <= 1'b0;
        sda_oe    <= 1'b0;
        owned     <= 1'b0;
        sto_pend  <= 1'b0;
        done      <= 1'b1;
        stat_code <= C_BUSERR;
      end else begin
        case (st)
          S_IDLE: if (accept) begin
            if (!cmd_en) begin
              scl_oe <= 1'b0;
              sda_oe <= 1'b0;
              owned  <= 1'b0;
            end else if (cmd_sta) begin
              st     <= S_START;
              step   <= '0;
              sda_oe <= 1'b0;
              cnt    <= half_m1;
              done   <= 1'b0;
            end else if (cmd_sto) begin
              st       <= S_STOP;
              step     <= '0;
              scl_oe   <= 1'b1;
              sda_oe   <= 1'b1;
              sto_pend <= 1'b1;
              cnt      <= half_m1;
              done     <= 1'b0;
            end else begin
              st     <= S_BYTE;
              step   <= '0;
              hi     <= 1'b0;
              rx_op  <= rx_next;
              ack_en <= cmd_ack;
              shreg  <= cmd_data;
              scl_oe <= 1'b1;
              sda_oe <= rx_next ? 1'b0 : !cmd_data[7];
              cnt    <= half_m1;
              done   <= 1'b0;
              if (addr_ph) rd_mode <= cmd_data[0];
            end
          end

          S_START: if (tick) begin
            cnt  <= half_m1;
            step <= step + 4'd1;
            case (step)
              4'd0: scl_oe <= 1'b0;
              4'd1: sda_oe <= 1'b1;
              4'd2: scl_oe <= 1'b1;
              default: begin
                st        <= S_IDLE;
                done      <= 1'b1;
                stat_code <= owned ? C_RSTART : C_START;
                owned     <= 1'b1;
                addr_ph   <= 1'b1;
              end
            endcase
          end

          S_BYTE: if (tick) begin
            cnt <= half_m1;
            if (!hi) begin
              hi     <= 1'b1;
              scl_oe <= 1'b0;
            end else begin
              hi     <= 1'b0;
              scl_oe <= 1'b1;
              if (step != 4'd8) begin
                shreg <= {shreg[6:0], sda_in};
                step  <= step + 4'd1;
                if (step == 4'd7) sda_oe <= rx_op ? ack_en : 1'b0;
                else              sda_oe <= rx_op ? 1'b0 : !shreg[6];
              end else begin
                st        <= S_IDLE;
                done      <= 1'b1;
                rx_byte   <= shreg;
                stat_code <= byte_code;
                addr_ph   <= 1'b0;
              end
            end
          end

          S_STOP: if (tick) begin
            cnt  <= half_m1;
            step <= step + 4'd1;
            case (step)
              4'd0: scl_oe <= 1'b0;
              4'd1: sda_oe <= 1'b0;
              default: begin
                st        <= S_IDLE;
                done      <= 1'b1;
                stat_code <= C_NONE;
                owned     <= 1'b0;
                sto_pend  <= 1'b0;
              end
            endcase
          end

          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/twm_master_chk.sv
`timescale 1ns/1ps
module twm_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] st,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       done,
  input logic       sto_pend,
  input logic [4:0] stat_code
);
  AST_SDA_HELD_WHILE_SCL_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && $past(st) == 2'd2 && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe)); // R5

  AST_NOT_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 2'd0) |-> !done); // R8

  AST_STOP_CLEARS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sto_pend) |-> done); // R7

  AST_STOP_LEAVES_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sto_pend) |-> (!scl_oe && !sda_oe)); // R7

  AST_BUSERR_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && stat_code == 5'h00) |-> (!scl_oe && !sda_oe)); // R10

  AST_CODE_IN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (stat_code inside {5'h00, 5'h01, 5'h02, 5'h03, 5'h04, 5'h05, 5'h06,
                                5'h08, 5'h09, 5'h0A, 5'h0B, 5'h1F})); // R4
endmodule

bind twm_master twm_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .done(done), .sto_pend(sto_pend), .stat_code(stat_code)
);

// File: tb/twm_master_bench.sv
`timescale 1ns/1ps
module twm_master_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       cmd_wr = 0, cmd_go = 0, cmd_en = 0, cmd_sta = 0, cmd_sto = 0, cmd_ack = 0;
  logic [7:0] cmd_data = '0;
  logic [7:0] rate_div = 8'd4;
  logic       scl_oe, sda_oe, done, sto_pend;
  logic [4:0] stat_code;
  logic [7:0] rx_byte;

  logic       sl_scl_hold = 0, sl_err = 0;
  logic [1:0] sl_mode = 0;
  logic [7:0] sl_byte = 0;
  int         bitn = 0, nb = 0;
  logic       sl_drv;
  wire scl = !(scl_oe || sl_scl_hold);
  wire sda = !(sda_oe || sl_drv || sl_err);
  assign sl_drv = (sl_mode == 2'd1 && nb == 8) ||
                  (sl_mode == 2'd2 && nb < 8 && !sl_byte[3'(7 - nb)]);

  logic [8:0] cap = '0;
  real t_rise = 0.0, per_ns = 0.0, hi_ns = 0.0;
  logic scl_p = 1, sda_p = 1, start_seen = 0, stop_seen = 0;
  int checks = 0, errors = 0;

  twm_master u_twm_master (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_go(cmd_go), .cmd_en(cmd_en),
    .cmd_sta(cmd_sta), .cmd_sto(cmd_sto), .cmd_ack(cmd_ack), .cmd_data(cmd_data),
    .rate_div(rate_div), .scl_in(scl), .sda_in(sda), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .done(done), .sto_pend(sto_pend), .stat_code(stat_code), .rx_byte(rx_byte)
  );

  always @(posedge scl) begin
    cap    = {cap[7:0], sda};
    bitn   = (bitn == 8) ? 0 : bitn + 1;
    per_ns = $realtime - t_rise;
    t_rise = $realtime;
  end
  always @(negedge scl) begin
    nb    = bitn;
    hi_ns = $realtime - t_rise;
  end
  always @(negedge clk) begin
    if (scl && scl_p && sda_p && !sda) begin bitn = 0; start_seen = 1; end
    if (scl && scl_p && !sda_p && sda) stop_seen = 1;
    scl_p = scl;
    sda_p = sda;
  end

  // kind[25:24] data[23:16] ack[15] slave_mode[14:13] slave_byte[12:5] code[4:0]
  localparam logic [25:0] VEC [14] = '{
    {2'd0, 8'h00, 1'b0, 2'd0, 8'h00, 5'h01},
    {2'd1, 8'h70, 1'b0, 2'd1, 8'h00, 5'h03},
    {2'd1, 8'hA5, 1'b0, 2'd1, 8'h00, 5'h05},
    {2'd1, 8'h3C, 1'b0, 2'd0, 8'h00, 5'h06},
    {2'd0, 8'h00, 1'b0, 2'd0, 8'h00, 5'h02},
    {2'd1, 8'h71, 1'b0, 2'd1, 8'h00, 5'h08},
    {2'd2, 8'h00, 1'b1, 2'd2, 8'h5A, 5'h0A},
    {2'd2, 8'h00, 1'b0, 2'd2, 8'hC3, 5'h0B},
    {2'd3, 8'h00, 1'b0, 2'd0, 8'h00, 5'h1F},
    {2'd0, 8'h00, 1'b0, 2'd0, 8'h00, 5'h01},
    {2'd1, 8'h70, 1'b0, 2'd0, 8'h00, 5'h04},
    {2'd0, 8'h00, 1'b0, 2'd0, 8'h00, 5'h02},
    {2'd1, 8'h71, 1'b0, 2'd0, 8'h00, 5'h09},
    {2'd3, 8'h00, 1'b0, 2'd0, 8'h00, 5'h1F}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_range(input string req, input real act, input real lo, input real hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual %0.1f expected %0.1f..%0.1f", req, act, lo, hi);
    end
  endtask

  task automatic issue(input logic [1:0] kind, input logic [7:0] d, input logic a,
                       input logic en, input logic go);
    cmd_sta  = (kind == 2'd0);
    cmd_sto  = (kind == 2'd3);
    cmd_data = d;
    cmd_ack  = a;
    cmd_en   = en;
    cmd_go   = go;
    cmd_wr   = 1'b1;
    @(negedge clk);
    cmd_wr   = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (!done) chk("R8 done never set", 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", done, 0);
    chk("R1 sto_pend after reset", sto_pend, 0);
    chk("R1 code after reset", stat_code, 5'h1F);
    chk("R1 lines free after reset", {scl, sda}, 2'b11);

    issue(2'd0, 8'h00, 1'b0, 1'b1, 1'b0);
    repeat (40) @(negedge clk);
    chk("R8 go clear ignored: done", done, 0);
    chk("R8 go clear ignored: no start", {start_seen, sda, scl}, 3'b011);

    for (int i = 0; i < 14; i++) begin
      automatic logic [25:0] v = VEC[i];
      automatic logic [1:0] kind = v[25:24];
      automatic string tag;
      case (v[4:0])
        5'h01: tag = "R2";
        5'h02: tag = "R3";
        5'h03, 5'h04, 5'h08, 5'h09: tag = "R4";
        5'h05, 5'h06: tag = "R5";
        5'h0A, 5'h0B: tag = "R6";
        default: tag = "R7";
      endcase
      sl_mode = v[14:13];
      sl_byte = v[12:5];
      start_seen = 0;
      stop_seen = 0;
      issue(kind, v[23:16], v[15], 1'b1, 1'b1);
      if (i == 0) chk("R8 done cleared on accept", done, 0);
      if (kind == 2'd3) chk("R7 sto_pend while stop runs", sto_pend, 1);
      wait_done();
      chk($sformatf("%s code vector %0d", tag, i), stat_code, v[4:0]);
      case (kind)
        2'd0: chk($sformatf("%s start edge and bus held, vector %0d", tag, i),
                  {start_seen, scl, sda}, 3'b100);
        2'd1: begin
          chk($sformatf("R5 bits on bus MSB first, vector %0d", i), cap[8:1], v[23:16]);
          chk($sformatf("%s slave ack bit, vector %0d", tag, i), cap[0], (v[14:13] == 2'd1) ? 0 : 1);
          chk($sformatf("R9 SCL period ns, vector %0d", i), int'(per_ns), 120);
        end
        2'd2: begin
          chk($sformatf("R6 received byte, vector %0d", i), rx_byte, v[12:5]);
          chk($sformatf("R6 master ack bit, vector %0d", i), cap[0], !v[15]);
        end
        default: begin
          chk("R7 sto_pend cleared", sto_pend, 0);
          chk("R7 stop edge and bus free", {stop_seen, scl, sda}, 3'b111);
        end
      endcase
    end

    sl_mode = 0;
    issue(2'd0, 8'h00, 1'b0, 1'b1, 1'b1);
    wait_done();
    chk("R2 start before disable", stat_code, 5'h01);
    issue(2'd0, 8'h00, 1'b0, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    chk("R11 disable releases lines", {scl, sda}, 2'b11);
    chk("R11 disable keeps done and code", {done, stat_code}, {1'b1, 5'h01});
    issue(2'd0, 8'h00, 1'b0, 1'b1, 1'b1);
    wait_done();
    chk("R11 next start is not repeated", stat_code, 5'h01);

    sl_mode = 2'd1;
    issue(2'd1, 8'h70, 1'b0, 1'b1, 1'b1);
    @(posedge scl);
    @(negedge scl);
    @(negedge clk);
    sl_scl_hold = 1'b1;
    repeat (20) @(negedge clk);
    sl_scl_hold = 1'b0;
    @(negedge scl);
    chk_range("R9 stretched high phase ns", hi_ns, 55.0, 60.0);
    wait_done();
    chk("R9 stretched byte code", stat_code, 5'h03);

    sl_mode = 2'd0;
    issue(2'd1, 8'hFF, 1'b0, 1'b1, 1'b1);
    @(posedge scl);
    repeat (2) @(negedge clk);
    sl_err = 1'b1;
    wait_done();
    chk("R10 bus error code", stat_code, 5'h00);
    chk("R10 lines released", {scl_oe, sda_oe, scl}, 3'b001);
    chk("R10 sto_pend clear", sto_pend, 0);
    repeat (4) @(negedge clk);
    sl_err = 1'b0;
    repeat (4) @(negedge clk);
    issue(2'd0, 8'h00, 1'b0, 1'b1, 1'b1);
    wait_done();
    chk("R10 start after bus error", stat_code, 5'h01);

    rate_div = 8'd10;
    sl_mode = 2'd1;
    issue(2'd1, 8'h70, 1'b0, 1'b1, 1'b1);
    wait_done();
    chk("R9 SCL period ns at divider 10", int'(per_ns), 180);
    sl_mode = 2'd0;
    issue(2'd3, 8'h00, 1'b0, 1'b1, 1'b1);
    wait_done();
    chk("R7 stop at divider 10", {sto_pend, scl, sda}, 3'b011);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule